// File: doc/BRIEF.md
# GPIO Controller with Level and Edge Interrupts

This block is a word-addressed GPIO controller for up to 32 pins. Software programs it through a plain synchronous register port: an address, a write strobe, write data and read data. Each pin has an output data bit and an output-enable bit, and the current pin level can be read back.

Every pin can raise an interrupt in two independent ways. The first is a level source, evaluated live from the synchronized input, a polarity bit and a mask bit. The second is an edge source. An edge source sets a sticky event flag on the selected edge, whether or not that pin is masked, and software clears the flag by writing a one to it.

All pending per-pin sources are ORed into one combined GPIO interrupt. That signal is reported in a small top-level status and mask window. The processor interrupt line rises only when the top-level mask bit is also set. Pin inputs pass through a two-flop synchronizer before anything looks at them.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Writing the output-data word at byte offset 0x04 sets `pin_out`, and writing the output-enable word at 0x08 sets `pin_oe`, from the clock edge that takes the write. A 1 in the enable word means the pin is driven. Both words read back as written.
- R2: A read of offset 0x00 returns the pin levels. These lag `pin_in` through a two-flop synchronizer, so a change made before clock edge k is visible after edge k+1. Writes to 0x00 have no effect.
- R3: A pin's level source is (synchronized input XOR level polarity bit) AND level mask bit. Level polarity is the word at 0x10 and level mask is the word at 0x14. A polarity bit of 0 means active-high and 1 means active-low. The level source is not latched.
- R4: The edge polarity word is at 0x24. Bit value 0 selects rising-edge detection and 1 selects falling-edge detection for that pin. An edge visible on the synchronized input after edge k+1 sets the pin's event flag at edge k+2.
- R5: Event flags set even when the pin's bit in the edge mask word (0x1C) is 0. A pin's pending edge source is its flag AND its mask bit, so unmasking a pin later exposes an edge that has already been captured.
- R6: The event flags are read at 0x18. Writing a 1 to a bit clears that flag, and writing a 0 leaves it unchanged. If a new edge and a clear reach the same flag in the same cycle, the flag ends up set.
- R7: Bit 0 of the top-level status word at 0x60 is the live OR over all pins of the pending level and pending edge sources. This bit does not depend on the top-level mask. Writes to 0x60 have no effect.
- R8: `cpu_irq` equals top-level status bit 0 AND bit 0 of the top-level mask word at 0x64.
- R9: After reset, every control word, every event flag, `pin_out`, `pin_oe` and `cpu_irq` are 0. All pins are therefore inputs and no interrupt is enabled.
- R10: Reads of any other address return 0, and writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 7 | Byte address of the register access |
| wr_en | input | 1 | Write strobe, taken at the rising clock edge |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational from registered state |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output data per pin |
| pin_oe | output | NPINS | Output enable per pin (1 = drive) |
| cpu_irq | output | 1 | Masked interrupt to the processor |

## Verification
The bench targets the cycle in which a clear write and a fresh edge meet on the same flag. A design that let the clear win would lose that event, and `cpu_irq` would drop a cycle too early.

It also captures edges while a pin is masked and only then unmasks it. A design that gated flag capture with the mask would show no pending interrupt at that point.

Polarity flips on the level path are exercised against live pin changes. A design that latched level sources, or that inverted the polarity meaning, would hold or raise the interrupt in the wrong cycles.

Writes to the input word, to the status word and to unmapped holes are checked through readback. A decoder that aliased addresses would be exposed by a word changing or a hole returning data.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int ADDR_W = 7;

    // Byte offsets of the register window
    localparam logic [ADDR_W-1:0] OFS_DIN   = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_DOUT  = 7'h04;
    localparam logic [ADDR_W-1:0] OFS_OE    = 7'h08;
    localparam logic [ADDR_W-1:0] OFS_LPOL  = 7'h10;
    localparam logic [ADDR_W-1:0] OFS_LMASK = 7'h14;
    localparam logic [ADDR_W-1:0] OFS_EVT   = 7'h18;
    localparam logic [ADDR_W-1:0] OFS_EMASK = 7'h1C;
    localparam logic [ADDR_W-1:0] OFS_EPOL  = 7'h24;
    localparam logic [ADDR_W-1:0] OFS_TSTAT = 7'h60;
    localparam logic [ADDR_W-1:0] OFS_TMASK = 7'h64;

    typedef struct packed {
        logic [31:0] dout;
        logic [31:0] oe;
        logic [31:0] lpol;
        logic [31:0] lmask;
        logic [31:0] emask;
        logic [31:0] epol;
        logic        tmask;
    } ctl_regs_t;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] din,
    output logic [N-1:0] din_prev
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stable;
        logic [N-1:0] last;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.meta   = pin_in;
        sync_d.stable = sync_q.meta;
        sync_d.last   = sync_q.stable;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign din      = sync_q.stable;
    assign din_prev = sync_q.last;

endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    input  logic [N-1:0] din_prev,
    input  logic [N-1:0] edge_pol,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    output logic [N-1:0] flags
);

    logic [N-1:0] hit;
    logic [N-1:0] flags_d, flags_q;

    for (genvar i = 0; i < N; i++) begin : g_pin
        always_comb begin
            if (edge_pol[i]) hit[i] = din_prev[i] & ~din[i];
            else             hit[i] = din[i] & ~din_prev[i];
        end
    end

    always_comb begin
        flags_d = flags_q;
        if (clr_en) flags_d = flags_d & ~clr_bits;
        flags_d = flags_d | hit;   // a fresh edge beats a clear
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

endmodule

// File: rtl/gpio_irq_combine.sv
module gpio_irq_combine #(
    parameter int N = 32
) (
    input  logic [N-1:0] din,
    input  logic [N-1:0] lvl_pol,
    input  logic [N-1:0] lvl_mask,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] evt_mask,
    output logic         irq_any
);

    logic [N-1:0] pend;

    for (genvar i = 0; i < N; i++) begin : g_pin
        assign pend[i] = ((din[i] ^ lvl_pol[i]) & lvl_mask[i])
                       | (flags[i] & evt_mask[i]);
    end

    assign irq_any = |pend;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              cpu_irq
);

    localparam logic [31:0] PIN_MASK = 32'hFFFF_FFFF >> (32 - NPINS);

    ctl_regs_t        regs_d, regs_q;
    logic [NPINS-1:0] din, din_prev, flags;
    logic             irq_any;
    logic             evt_clr;
    logic [31:0]      wmask;

    assign wmask   = wdata & PIN_MASK;
    assign evt_clr = wr_en && (addr == OFS_EVT);

    gpio_in_sync #(.N(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .din      (din),
        .din_prev (din_prev)
    );

    gpio_edge_flags #(.N(NPINS)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (din),
        .din_prev (din_prev),
        .edge_pol (regs_q.epol[NPINS-1:0]),
        .clr_en   (evt_clr),
        .clr_bits (wdata[NPINS-1:0]),
        .flags    (flags)
    );

    gpio_irq_combine #(.N(NPINS)) u_comb (
        .din      (din),
        .lvl_pol  (regs_q.lpol[NPINS-1:0]),
        .lvl_mask (regs_q.lmask[NPINS-1:0]),
        .flags    (flags),
        .evt_mask (regs_q.emask[NPINS-1:0]),
        .irq_any  (irq_any)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (addr)
                OFS_DOUT:  regs_d.dout  = wmask;
                OFS_OE:    regs_d.oe    = wmask;
                OFS_LPOL:  regs_d.lpol  = wmask;
                OFS_LMASK: regs_d.lmask = wmask;
                OFS_EMASK: regs_d.emask = wmask;
                OFS_EPOL:  regs_d.epol  = wmask;
                OFS_TMASK: regs_d.tmask = wdata[0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (addr)
            OFS_DIN:   rdata = 32'(din);
            OFS_DOUT:  rdata = regs_q.dout;
            OFS_OE:    rdata = regs_q.oe;
            OFS_LPOL:  rdata = regs_q.lpol;
            OFS_LMASK: rdata = regs_q.lmask;
            OFS_EVT:   rdata = 32'(flags);
            OFS_EMASK: rdata = regs_q.emask;
            OFS_EPOL:  rdata = regs_q.epol;
            OFS_TSTAT: rdata = {31'd0, irq_any};
            OFS_TMASK: rdata = {31'd0, regs_q.tmask};
            default:   rdata = 32'd0;
        endcase
    end

    assign pin_out = regs_q.dout[NPINS-1:0];
    assign pin_oe  = regs_q.oe[NPINS-1:0];
    assign cpu_irq = irq_any & regs_q.tmask;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [NPINS-1:0]  pin_in,
    input logic [NPINS-1:0]  pin_oe,
    input logic              cpu_irq,
    input logic              irq_any,
    input logic [NPINS-1:0]  din,
    input logic [NPINS-1:0]  lpol,
    input logic [NPINS-1:0]  lmask,
    input logic [NPINS-1:0]  flags
);

    logic [1:0] age_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    // R8: the processor line never rises without the combined source
    assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq |-> irq_any);

    // R6: flags only fall on a write to the event word
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFS_EVT) |=> ((flags & $past(flags)) == $past(flags)));

    // R2: input word lags the pins by two edges
    assert_din_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (din == $past(pin_in, 2)));

    // R3: an active level source always reaches the combined line
    assert_level_feeds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (|((din ^ lpol) & lmask)) |-> irq_any);

    // R1: enables move only on a write to the enable word
    assert_oe_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == OFS_OE) |=> $stable(pin_oe));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .pin_in  (pin_in),
    .pin_oe  (pin_oe),
    .cpu_irq (cpu_irq),
    .irq_any (irq_any),
    .din     (din),
    .lpol    (regs_q.lpol[NPINS-1:0]),
    .lmask   (regs_q.lmask[NPINS-1:0]),
    .flags   (flags)
);

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;

    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [6:0]    addr = '0;
    logic          wr_en = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          cpu_irq;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    gpio_irq_ctrl #(.NPINS(NP)) i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .cpu_irq(cpu_irq)
    );

    // ---------------- behavioural reference ----------------
    logic [31:0] m_s1, m_s2, m_prev, m_dout, m_oe, m_lpol, m_lmask;
    logic [31:0] m_flags, m_emask, m_epol;
    logic        m_tmask;

    function automatic logic m_status();
        return |(((m_s2 ^ m_lpol) & m_lmask) | (m_flags & m_emask));
    endfunction

    function automatic logic [31:0] m_read(input logic [6:0] a);
        case (a)
            7'h00: return m_s2;
            7'h04: return m_dout;
            7'h08: return m_oe;
            7'h10: return m_lpol;
            7'h14: return m_lmask;
            7'h18: return m_flags;
            7'h1C: return m_emask;
            7'h24: return m_epol;
            7'h60: return {31'd0, m_status()};
            7'h64: return {31'd0, m_tmask};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [6:0] a);
        case (a)
            7'h00: return "R2";
            7'h04, 7'h08: return "R1";
            7'h10, 7'h14: return "R3";
            7'h18: return "R6";
            7'h1C: return "R5";
            7'h24: return "R4";
            7'h60: return "R7";
            7'h64: return "R8";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_s1, m_s2, m_prev, m_dout, m_oe, m_lpol, m_lmask} = '0;
            {m_flags, m_emask, m_epol} = '0;
            m_tmask = 1'b0;
        end else begin
            logic [31:0] rise, fall, hit, nf;
            rise = m_s2 & ~m_prev;
            fall = ~m_s2 & m_prev;
            hit  = (rise & ~m_epol) | (fall & m_epol);
            nf   = m_flags;
            if (wr_en && addr == 7'h18) nf = nf & ~wdata;
            nf = nf | hit;
            if (wr_en) begin
                case (addr)
                    7'h04: m_dout  = wdata;
                    7'h08: m_oe    = wdata;
                    7'h10: m_lpol  = wdata;
                    7'h14: m_lmask = wdata;
                    7'h1C: m_emask = wdata;
                    7'h24: m_epol  = wdata;
                    7'h64: m_tmask = wdata[0];
                    default: ;
                endcase
            end
            m_flags = nf;
            m_prev  = m_s2;
            m_s2    = m_s1;
            m_s1    = pin_in;
        end
    end

    task automatic cmp(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            cmp("R8", "cpu_irq", {31'd0, cpu_irq}, {31'd0, m_tmask & m_status()});
            cmp("R1", "pin_out", pin_out, m_dout);
            cmp("R1", "pin_oe", pin_oe, m_oe);
            cmp(tag_of(addr), $sformatf("rdata@%h", addr), rdata, m_read(addr));
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b1; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a);
        @(negedge clk);
        addr = a;
        idle(1);
    endtask

    task automatic pins(input logic [31:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] lcg;
        lcg = 32'h1234_5678;
        idle(3);
        @(negedge clk) rst_n = 1'b1;
        #2;
        // R9: reset state
        cmp("R9", "pin_oe after reset", pin_oe, 32'd0);
        cmp("R9", "pin_out after reset", pin_out, 32'd0);
        cmp("R9", "cpu_irq after reset", {31'd0, cpu_irq}, 32'd0);
        foreach (i_addrs[k]) begin end
        rd(7'h18); rd(7'h24); rd(7'h10); rd(7'h64);

        // R1 output words
        wr(7'h04, 32'hA5A5_0F0F); wr(7'h08, 32'hFFFF_0000);
        rd(7'h04); rd(7'h08);
        // R2 / R7 writes ignored
        wr(7'h00, 32'hFFFF_FFFF); rd(7'h00);
        wr(7'h60, 32'h1); rd(7'h60);

        // R2 input sampling with varied patterns
        addr = 7'h00;
        for (int i = 0; i < 20; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            pins(lcg);
            idle(i % 3);
        end

        // R3 level sources, R8 top mask
        wr(7'h10, 32'h0000_FFFF);
        wr(7'h14, 32'h00FF_00FF);
        wr(7'h64, 32'h1);
        addr = 7'h60;
        for (int i = 0; i < 16; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            pins(lcg & 32'h0F0F_0F0F);
            idle(2);
        end
        pins(32'h0000_FFFF); idle(4);     // all active-low pins high, high ones low
        wr(7'h10, 32'h0000_0000); idle(2); // flip polarity live
        wr(7'h14, 32'h0); pins(32'h0); idle(4);

        // R4 / R5 edges, captured while masked
        wr(7'h24, 32'hFF00_FF00);
        wr(7'h1C, 32'h0);
        pins(32'hFFFF_FFFF); idle(4);
        pins(32'h0000_0000); idle(4);
        rd(7'h18); rd(7'h60);
        wr(7'h1C, 32'h0F0F_0F0F); rd(7'h60);
        wr(7'h1C, 32'hFFFF_FFFF);

        // R6 partial clear and zero write
        wr(7'h18, 32'h0000_FFFF); rd(7'h18);
        wr(7'h18, 32'h0000_0000); rd(7'h18);
        for (int i = 0; i < 12; i++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            pins(lcg);
            idle(1 + i % 2);
            if (i % 4 == 3) wr(7'h18, lcg ^ 32'h5A5A_5A5A);
        end
        wr(7'h18, 32'hFFFF_FFFF);

        // R6 clear meets new edge in various cycles
        wr(7'h24, 32'h0);
        for (int d = 0; d < 4; d++) begin
            pins(32'h0); idle(4);
            wr(7'h18, 32'hFFFF_FFFF);
            pins(32'hFFFF_FFFF);
            idle(d);
            wr(7'h18, 32'hFFFF_FFFF);
            rd(7'h18); rd(7'h60);
        end

        // R10 unmapped accesses
        wr(7'h0C, 32'hDEAD_BEEF); wr(7'h3C, 32'hDEAD_BEEF); wr(7'h20, 32'h1);
        rd(7'h0C); rd(7'h20); rd(7'h44); rd(7'h7C); rd(7'h05);
        rd(7'h04); rd(7'h08); rd(7'h1C); rd(7'h24);

        // R8 top mask off while status stays set
        wr(7'h64, 32'h0); rd(7'h60); idle(3);
        wr(7'h64, 32'h1); idle(3);
        idle(4);
        summary();
    end

    logic [1:0] i_addrs [1];

endmodule